// File: doc/BRIEF.md
# Flash Command Interface and Program/Erase Sequencer

This block is the control front end of a behavioural boot-block flash array. A host issues bus writes and reads over a simple synchronous valid/ready bus. Writes carry command codes in the low byte of the write data. A word program or a block erase always takes two consecutive writes: a setup write, then a second write. For a program, the second write gives the target address and the data. For an erase, it is a confirm code sent to an address inside the target block. An internal sequencer then stays busy for a parameterised number of cycles and applies the operation to the array. A program may be suspended so that other blocks can be read. An erase may be suspended so that other blocks can be read or programmed. The sequencer later resumes from where it stopped.

A status word reports readiness, suspension and sticky error flags. The two parameter blocks at the boot end of the map can be write-protected by a level input. The boot end is at the top or at the bottom of the map, as chosen by `BOOT_TOP`. An active-low reset/power-down input clears the sequencer and the status flags and closes the bus. After it is released, the bus reopens only once a fixed warm-up period has passed.

Bus rules: `bus_ready` is low only while `pwr_n` is low and during the warm-up period. A transfer happens on a clock edge where both `bus_valid` and `bus_ready` are high. The read response has no back-pressure: `rsp_valid` pulses for one cycle and the host must take `rsp_data` in that cycle.

Command codes (`bus_wdata[7:0]`): 8'hFF read-array mode, 8'h70 status mode, 8'h50 clear error flags, 8'h40 program setup, 8'h20 erase setup, 8'hD0 erase confirm or resume, 8'hB0 suspend. Status word bits (`[15:8]` are always zero):

| Bit | Meaning |
|-----|---------|
| 7 | ready (sequencer not busy) |
| 6 | erase suspended |
| 5 | erase failed |
| 4 | program failed |
| 3 | command-sequence error |
| 2 | program suspended |
| 1 | lock violation |
| 0 | always 0 |

Top module: `flash_cmd_seq`

## Requirements
- R1: While `pwr_n` is low, `bus_ready` and `rsp_valid` are 0 and no command is taken. Releasing `pwr_n` leaves the status word at 16'h0080.
- R2: After `pwr_n` rises, `bus_ready` goes high on the `WARM_CYC`-th rising clock edge and not before.
- R3: A read accepted at edge E gives `rsp_valid` = 1 after edge E. In read-array mode, with the sequencer not busy, `rsp_data` is the word at `bus_addr`.
- R4: Program setup (8'h40) followed by a write of address/data starts a program. The status shows not-ready for reads accepted at edges T+1 through T+`PROG_CYC`, where T is the edge of the second write. A read at T+`PROG_CYC`+1 shows ready. The stored word becomes the old word AND the data, so bits only change from 1 to 0.
- R5: Erase setup (8'h20) then 8'hD0 to an address in block B sets every word of block B to 16'hFFFF after `ERASE_CYC` busy cycles, with the same timing rule as R4. Other blocks are unchanged.
- R6: While the sequencer is busy, every read returns the status word. After a program or an erase starts, reads keep returning status until a read-array command.
- R7: Suspend (8'hB0) during a program stops it, sets bits 7 and 2, and leaves the target word unchanged. Other addresses read correctly while suspended. 8'hD0 resumes the program, and it completes.
- R8: Suspend during an erase sets bits 7 and 6. A program to another block may then run (status bit 7 low, bit 6 high) and completes. 8'hD0 resumes the erase, and it completes.
- R9: With `wp_lock` high, a program or erase aimed at one of the two boot-end blocks (blocks `NUM_BLK`-1 and `NUM_BLK`-2 when `BOOT_TOP`=1) leaves the array unchanged and keeps bit 7 set. It sets bit 1 plus bit 4 (program) or bit 5 (erase). Other blocks are still programmable, and the boot blocks are writable when `wp_lock` is low.
- R10: An unknown command code, or an erase second write other than 8'hD0, sets bit 3 and returns the interface to read-array mode.
- R11: 8'h50 clears bits 5, 4, 3 and 1. Without it, these bits stay set.
- R12: While a program is suspended, a new erase is refused with bit 3. While an erase is suspended, a program to the block being erased is refused with bit 4, and the array is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| pwr_n | input | 1 | Active-low asynchronous reset / power-down |
| wp_lock | input | 1 | High protects the two boot-end blocks |
| bus_valid | input | 1 | Host transfer request |
| bus_ready | output | 1 | Block can accept a transfer |
| bus_we | input | 1 | 1 = write (command), 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 16 | Command code in [7:0], or program data |
| rsp_valid | output | 1 | Read data valid for one cycle |
| rsp_data | output | 16 | Array word or status word |

## Verification
Each result is due a fixed number of cycles after the stimulus that causes it. Read data arrives in the cycle after the read is accepted. A program or erase whose second write is accepted at edge T reports busy to reads at T+1 through T+`PROG_CYC` (or `ERASE_CYC`) and ready from T+`PROG_CYC`+1 (or `ERASE_CYC`+1). Lock and sequence errors show on the very next read. The bench issues one transfer per clock, so it knows the edge at which each read lands. It places busy-status reads exactly on the last busy edge and the first ready edge, and it counts the warm-up edges one by one. A scoreboard queue pairs each read with its expected word and compares at the falling edge after `rsp_valid` rises.

// File: rtl/fci_pkg.sv
package fci_pkg;
  localparam logic [7:0] CMD_READ    = 8'hFF;
  localparam logic [7:0] CMD_STAT    = 8'h70;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;
  localparam logic [7:0] CMD_PROG    = 8'h40;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_SUSP    = 8'hB0;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_PROG, SQ_ERASE, SQ_PSUSP, SQ_ESUSP, SQ_ESPROG
  } sq_state_e;

  typedef enum logic [1:0] {ARM_NONE, ARM_PROG, ARM_ERASE} arm_e;
endpackage

// File: rtl/fci_lock.sv
module fci_lock #(
  parameter int NUM_BLK  = 8,
  parameter bit BOOT_TOP = 1'b1,
  localparam int BLK_W   = $clog2(NUM_BLK)
) (
  input  logic [BLK_W-1:0] blk,
  input  logic             wp_lock,
  output logic             locked
);
  logic boot_blk;
  generate
    if (BOOT_TOP) begin : g_top
      assign boot_blk = (blk >= BLK_W'(NUM_BLK - 2));
    end else begin : g_bot
      assign boot_blk = (blk < BLK_W'(2));
    end
  endgenerate
  assign locked = wp_lock & boot_blk;
endmodule

// File: rtl/fci_array.sv
module fci_array #(
  parameter int ADDR_W = 7,
  parameter int OFFS_W = 4,
  parameter int DATA_W = 16,
  localparam int BLK_W = ADDR_W - OFFS_W,
  localparam int NW    = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              arm_n,
  input  logic              prog_en,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [DATA_W-1:0] prog_data,
  input  logic              erase_en,
  input  logic [BLK_W-1:0]  erase_blk,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [NW];
  logic [DATA_W-1:0] cur_word;

  initial begin
    for (int i = 0; i < NW; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NW; i++) begin
      if (erase_en && BLK_W'(i >> OFFS_W) == erase_blk) mem[i] <= '1;
      else if (prog_en && ADDR_W'(i) == prog_addr) mem[i] <= mem[i] & prog_data;
    end
  end

  assign rd_data  = mem[rd_addr];
  assign cur_word = mem[prog_addr];

  // R5: first word of an erased block reads all ones afterwards
  p_erase_ones_r5: assert property (@(posedge clk) disable iff (!arm_n)
    erase_en |=> mem[{$past(erase_blk), {OFFS_W{1'b0}}}] == '1);
  // R4: a program only clears bits
  p_prog_and_r4: assert property (@(posedge clk) disable iff (!arm_n)
    prog_en |=> mem[$past(prog_addr)] == ($past(cur_word) & $past(prog_data)));
  p_no_overlap_r5: assert property (@(posedge clk) disable iff (!arm_n)
    !(prog_en && erase_en));
endmodule

// File: rtl/fci_seq.sv
module fci_seq
  import fci_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int OFFS_W    = 4,
  parameter int DATA_W    = 16,
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 20,
  localparam int BLK_W    = ADDR_W - OFFS_W,
  localparam int MAXC     = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC,
  localparam int CW       = $clog2(MAXC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_prog,
  input  logic              start_erase,
  input  logic              suspend,
  input  logic              resume,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy,
  output logic              prog_susp,
  output logic              erase_susp,
  output logic              prog_done,
  output logic              erase_done,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic [BLK_W-1:0]  erase_blk
);
  sq_state_e st;
  logic [CW-1:0] p_cnt, e_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= SQ_IDLE; p_cnt <= '0; e_cnt <= '0;
      prog_addr <= '0; prog_data <= '0; erase_blk <= '0;
    end else begin
      case (st)
        SQ_IDLE: begin
          if (start_prog) begin
            st <= SQ_PROG; p_cnt <= CW'(PROG_CYC - 1);
            prog_addr <= addr_i; prog_data <= data_i;
          end else if (start_erase) begin
            st <= SQ_ERASE; e_cnt <= CW'(ERASE_CYC - 1);
            erase_blk <= addr_i[ADDR_W-1:OFFS_W];
          end
        end
        SQ_PROG: begin
          if (p_cnt == '0) st <= SQ_IDLE;
          else if (suspend) st <= SQ_PSUSP;
          else p_cnt <= p_cnt - 1'b1;
        end
        SQ_ERASE: begin
          if (e_cnt == '0) st <= SQ_IDLE;
          else if (suspend) st <= SQ_ESUSP;
          else e_cnt <= e_cnt - 1'b1;
        end
        SQ_PSUSP: if (resume) st <= SQ_PROG;
        SQ_ESUSP: begin
          if (start_prog) begin
            st <= SQ_ESPROG; p_cnt <= CW'(PROG_CYC - 1);
            prog_addr <= addr_i; prog_data <= data_i;
          end else if (resume) st <= SQ_ERASE;
        end
        SQ_ESPROG: begin
          if (p_cnt == '0) st <= SQ_ESUSP;
          else p_cnt <= p_cnt - 1'b1;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign busy       = (st == SQ_PROG) || (st == SQ_ERASE) || (st == SQ_ESPROG);
  assign prog_susp  = (st == SQ_PSUSP);
  assign erase_susp = (st == SQ_ESUSP) || (st == SQ_ESPROG);
  assign prog_done  = ((st == SQ_PROG) || (st == SQ_ESPROG)) && (p_cnt == '0);
  assign erase_done = (st == SQ_ERASE) && (e_cnt == '0);

  // R7: program and erase suspension never coexist
  p_susp_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_susp && erase_susp));
  // R7: a suspended program keeps its remaining count until resumed
  p_psusp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_susp && !resume) |=> (prog_susp && $stable(p_cnt)));
  // R8: resuming a suspended erase makes the sequencer busy again
  p_eresume_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_ESUSP && resume && !start_prog) |=> (busy && !erase_susp));
  // R4: completion leaves the sequencer not busy unless an erase is suspended
  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_PROG && prog_done) |=> !busy);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fci_pkg::*;
#(
  parameter int NUM_BLK   = 8,
  parameter int BLK_WORDS = 16,
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 20,
  parameter int WARM_CYC  = 5,
  parameter bit BOOT_TOP  = 1'b1,
  localparam int OFFS_W   = $clog2(BLK_WORDS),
  localparam int BLK_W    = $clog2(NUM_BLK),
  localparam int ADDR_W   = OFFS_W + BLK_W
) (
  input  logic              clk,
  input  logic              pwr_n,
  input  logic              wp_lock,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic              rsp_valid,
  output logic [15:0]       rsp_data
);
  localparam int WW = $clog2(WARM_CYC + 1);

  logic [WW-1:0] warm;
  logic wr, rd, blk_locked;
  logic [7:0] cmd;
  logic [BLK_W-1:0] blk;
  arm_e armed;
  logic mode_stat;
  logic lock_q, pfail_q, efail_q, seq_q;
  logic start_prog, start_erase, sq_susp, sq_resume, clr;
  logic lock_set, pfail_set, efail_set, seq_set;
  logic sq_busy, psusp, esusp, pdone, edone;
  logic [ADDR_W-1:0] pa;
  logic [15:0] pd, arr_rd, status;
  logic [BLK_W-1:0] eblk;

  always_ff @(posedge clk or negedge pwr_n) begin
    if (!pwr_n) warm <= WW'(WARM_CYC);
    else if (warm != '0) warm <= warm - 1'b1;
  end
  assign bus_ready = (warm == '0);

  assign wr  = bus_valid & bus_ready & bus_we;
  assign rd  = bus_valid & bus_ready & ~bus_we;
  assign cmd = bus_wdata[7:0];
  assign blk = bus_addr[ADDR_W-1:OFFS_W];

  fci_lock #(.NUM_BLK(NUM_BLK), .BOOT_TOP(BOOT_TOP)) i_lock (
    .blk(blk), .wp_lock(wp_lock), .locked(blk_locked));

  always_comb begin
    start_prog = 1'b0; start_erase = 1'b0; sq_susp = 1'b0; sq_resume = 1'b0;
    clr = 1'b0; lock_set = 1'b0; pfail_set = 1'b0; efail_set = 1'b0; seq_set = 1'b0;
    if (wr) begin
      if (sq_busy) begin
        sq_susp = (cmd == CMD_SUSP);
      end else begin
        case (armed)
          ARM_PROG: begin
            if (psusp) seq_set = 1'b1;
            else if (blk_locked) begin lock_set = 1'b1; pfail_set = 1'b1; end
            else if (esusp && blk == eblk) pfail_set = 1'b1;
            else start_prog = 1'b1;
          end
          ARM_ERASE: begin
            if (cmd != CMD_CONFIRM || psusp || esusp) seq_set = 1'b1;
            else if (blk_locked) begin lock_set = 1'b1; efail_set = 1'b1; end
            else start_erase = 1'b1;
          end
          default: begin
            case (cmd)
              CMD_CLEAR:   clr = 1'b1;
              CMD_CONFIRM: sq_resume = psusp | esusp;
              CMD_READ, CMD_STAT, CMD_PROG, CMD_ERASE, CMD_SUSP: ;
              default:     seq_set = 1'b1;
            endcase
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge pwr_n) begin
    if (!pwr_n) begin
      armed <= ARM_NONE; mode_stat <= 1'b0;
      lock_q <= 1'b0; pfail_q <= 1'b0; efail_q <= 1'b0; seq_q <= 1'b0;
    end else begin
      if (wr && !sq_busy) begin
        if (armed != ARM_NONE) begin
          armed <= ARM_NONE;
          mode_stat <= !seq_set;
        end else begin
          case (cmd)
            CMD_READ:              mode_stat <= 1'b0;
            CMD_STAT, CMD_CONFIRM: mode_stat <= 1'b1;
            CMD_PROG:              armed <= ARM_PROG;
            CMD_ERASE:             armed <= ARM_ERASE;
            CMD_CLEAR, CMD_SUSP:   ;
            default:               mode_stat <= 1'b0;
          endcase
        end
      end
      lock_q  <= lock_set  | (lock_q  & ~clr);
      pfail_q <= pfail_set | (pfail_q & ~clr);
      efail_q <= efail_set | (efail_q & ~clr);
      seq_q   <= seq_set   | (seq_q   & ~clr);
    end
  end

  fci_seq #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .DATA_W(16),
            .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) i_seq (
    .clk(clk), .rst_n(pwr_n), .start_prog(start_prog), .start_erase(start_erase),
    .suspend(sq_susp), .resume(sq_resume), .addr_i(bus_addr), .data_i(bus_wdata),
    .busy(sq_busy), .prog_susp(psusp), .erase_susp(esusp), .prog_done(pdone),
    .erase_done(edone), .prog_addr(pa), .prog_data(pd), .erase_blk(eblk));

  fci_array #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .DATA_W(16)) i_array (
    .clk(clk), .arm_n(pwr_n), .prog_en(pdone), .prog_addr(pa), .prog_data(pd),
    .erase_en(edone), .erase_blk(eblk), .rd_addr(bus_addr), .rd_data(arr_rd));

  assign status = {8'h00, ~sq_busy, esusp, efail_q, pfail_q, seq_q, psusp, lock_q, 1'b0};

  always_ff @(posedge clk or negedge pwr_n) begin
    if (!pwr_n) begin
      rsp_valid <= 1'b0; rsp_data <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_data <= (mode_stat || sq_busy) ? status : arr_rd;
    end
  end

  // R3: every accepted read is answered on the next cycle
  p_rsp_next_r3: assert property (@(posedge clk) disable iff (!pwr_n)
    rd |=> rsp_valid);
  // R2: no response appears unless the bus was open
  p_warm_gate_r2: assert property (@(posedge clk) disable iff (!pwr_n)
    rsp_valid |-> $past(bus_ready));
  // R9: a program refused by the lock never starts the sequencer
  p_lock_refuse_r9: assert property (@(posedge clk) disable iff (!pwr_n)
    (wr && !sq_busy && !psusp && !esusp && armed == ARM_PROG && blk_locked)
      |=> (!sq_busy && lock_q && pfail_q));
  // R11: error flags persist until a clear command
  p_sticky_r11: assert property (@(posedge clk) disable iff (!pwr_n)
    (seq_q && !clr) |=> seq_q);
endmodule

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
  localparam int NUM_BLK = 8, BLK_WORDS = 16, PROG_CYC = 4, ERASE_CYC = 20, WARM_CYC = 5;
  localparam int ADDR_W = 7;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic pwr_n = 1'b0, wp_lock = 1'b0, bus_valid = 1'b0, bus_we = 1'b0;
  logic bus_ready, rsp_valid;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, rsp_data;

  int n_chk = 0, n_err = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  flash_cmd_seq #(.NUM_BLK(NUM_BLK), .BLK_WORDS(BLK_WORDS), .PROG_CYC(PROG_CYC),
                  .ERASE_CYC(ERASE_CYC), .WARM_CYC(WARM_CYC), .BOOT_TOP(1'b1)) i_flash_cmd_seq (
    .clk(clk), .pwr_n(pwr_n), .wp_lock(wp_lock), .bus_valid(bus_valid),
    .bus_ready(bus_ready), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bus_valid = 1'b0;
      @(posedge clk);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [15:0] d);
    @(negedge clk); bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_valid = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [15:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk); #1 bus_valid = 1'b0;
  endtask

  task automatic stat(input logic [15:0] exp, input string tag);
    wr(0, 16'h0070); rd(0, exp, tag);
  endtask

  // monitor: scoreboard compare
  always @(negedge clk) begin
    if (rsp_valid) begin
      if (exp_q.size() == 0) check("R3 unexpected response", rsp_data, 16'hxxxx);
      else begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, rsp_data, e);
      end
    end
  end

  task automatic power_up;
    int n;
    @(negedge clk); pwr_n = 1'b1;
    n = 0;
    do begin @(posedge clk); #1 n++; end while (!bus_ready && n < 100);
    check("R2 warm-up edges", 16'(n), 16'(WARM_CYC));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1 bus_ready low in power-down", {15'd0, bus_ready}, 16'h0000);
    check("R1 rsp_valid low in power-down", {15'd0, rsp_valid}, 16'h0000);
    power_up();
    stat(16'h0080, "R1 status after release");

    // R3 read array
    wr(0, 16'h00FF);
    rd(5, 16'hFFFF, "R3 read erased word");
    rd(100, 16'hFFFF, "R3 back-to-back read");

    // R4 program with busy window
    wr(0, 16'h0040); wr(20, 16'h1234);
    rd(20, 16'h0000, "R6 busy read returns status");
    idle(PROG_CYC - 2);
    rd(20, 16'h0000, "R4 still busy on last busy edge");
    rd(20, 16'h0080, "R4 ready on following edge");
    wr(0, 16'h00FF);
    rd(20, 16'h1234, "R4 programmed word");
    wr(0, 16'h0040); wr(20, 16'hFF0F); idle(PROG_CYC + 1);
    wr(0, 16'h00FF);
    rd(20, 16'h1204, "R4 program only clears bits");
    wr(0, 16'h0040); wr(40, 16'h00F0); idle(PROG_CYC + 1);

    // R5 erase block 1
    wr(16, 16'h0020); wr(16, 16'h00D0);
    rd(0, 16'h0000, "R5 erase busy");
    idle(ERASE_CYC - 2);
    rd(0, 16'h0000, "R5 still busy on last busy edge");
    rd(0, 16'h0080, "R5 ready on following edge");
    wr(0, 16'h00FF);
    rd(20, 16'hFFFF, "R5 erased word");
    rd(31, 16'hFFFF, "R5 last word of block erased");
    rd(40, 16'h00F0, "R5 other block unchanged");

    // R7 program suspend / resume, R12 erase refused while suspended
    wr(0, 16'h0040); wr(50, 16'h0F0F);
    wr(0, 16'h00B0);
    rd(0, 16'h0084, "R7 program suspended status");
    wr(0, 16'h00FF);
    rd(40, 16'h00F0, "R7 read other block while suspended");
    rd(50, 16'hFFFF, "R7 target not yet written");
    wr(32, 16'h0020); wr(32, 16'h00D0);
    stat(16'h008C, "R12 erase refused during program suspend");
    wr(0, 16'h0050);
    rd(0, 16'h0084, "R11 clear keeps suspend bit");
    wr(0, 16'h00D0); idle(PROG_CYC + 2);
    wr(0, 16'h00FF);
    rd(50, 16'h0F0F, "R7 resumed program completes");

    // R8 erase suspend with program to another block
    wr(0, 16'h0040); wr(66, 16'h0000); idle(PROG_CYC + 1);
    wr(64, 16'h0020); wr(64, 16'h00D0); idle(3);
    wr(0, 16'h00B0);
    rd(0, 16'h00C0, "R8 erase suspended status");
    wr(0, 16'h0040); wr(85, 16'hA5A5);
    rd(0, 16'h0040, "R8 program running in erase suspend");
    idle(PROG_CYC);
    rd(0, 16'h00C0, "R8 back to erase suspended");
    wr(0, 16'h0040); wr(70, 16'h0000);
    rd(0, 16'h00D0, "R12 program to suspended erase block refused");
    wr(0, 16'h00FF);
    rd(70, 16'hFFFF, "R12 array unchanged");
    rd(85, 16'hA5A5, "R8 program during suspend");
    wr(0, 16'h0050);
    wr(0, 16'h00D0); idle(ERASE_CYC + 1);
    stat(16'h0080, "R8 erase completed");
    wr(0, 16'h00FF);
    rd(66, 16'hFFFF, "R8 erased after resume");
    rd(85, 16'hA5A5, "R8 other block kept");

    // R9 lock
    wp_lock = 1'b1;
    wr(0, 16'h0040); wr(115, 16'h0000);
    rd(0, 16'h0092, "R9 locked program refused");
    wr(96, 16'h0020); wr(96, 16'h00D0);
    rd(0, 16'h00B2, "R9 locked erase refused");
    wr(0, 16'h0040); wr(90, 16'h1111); idle(PROG_CYC + 1);
    wr(0, 16'h00FF);
    rd(115, 16'hFFFF, "R9 locked word unchanged");
    rd(90, 16'h1111, "R9 unlocked block programmable");
    wr(0, 16'h0050);
    stat(16'h0080, "R11 clear status");
    wp_lock = 1'b0;
    wr(0, 16'h0040); wr(115, 16'h00FF); idle(PROG_CYC + 1);
    wr(0, 16'h00FF);
    rd(115, 16'h00FF, "R9 boot block writable when unlocked");

    // R10 sequence errors
    wr(0, 16'h0033);
    rd(90, 16'h1111, "R10 unknown command returns read array");
    stat(16'h0088, "R10 unknown command flag");
    wr(0, 16'h0050);
    wr(16, 16'h0020); wr(16, 16'h0077);
    rd(90, 16'h1111, "R10 bad confirm returns read array");
    stat(16'h0088, "R10 bad confirm flag");
    stat(16'h0088, "R11 flag sticky");

    // R1 power-down clears status
    idle(2);
    @(negedge clk); pwr_n = 1'b0;
    @(posedge clk); #1;
    check("R1 bus closed in power-down", {15'd0, bus_ready}, 16'h0000);
    idle(2);
    power_up();
    stat(16'h0080, "R1 status cleared by power-down");

    idle(3);
    check("R3 all responses seen", 16'(exp_q.size()), 16'h0000);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule